// File: doc/BRIEF.md
# Down-Counting Capture Timer

This block is a free-running timer whose count falls by one on every enabled clock. When the count reaches zero, the next enabled clock loads it from a period register instead. After reset the period register holds all ones, which is the normal setting for timing work: with it, the count simply wraps through every value.

A rising edge on an asynchronous capture input copies the running count into the compare register, so that one register serves both as compare and as capture. Software reads the captured value to work out timing.

- **Elapsed time:** the period minus the captured value, when timing begins at a fresh load.
- **Input signal period:** the earlier capture minus the later one. The subtraction runs in that order because the count runs downward.

A pending flag shows that a capture is waiting to be read. An overrun flag shows that a capture was overwritten before it was read. A single interrupt line can be pointed at one of three events (compare match, terminal count or capture) or turned off.

Top module: `captureTimer`

## Requirements
- R1: While reset is asserted (rstN low), count reads all ones, cmpValue reads zero, and capPending, capOverrun and irq read low.
- R2: While enable is high, count falls by one per clock, and a clock that sees count at zero loads the period value instead. After reset the period value is all ones. While enable is low, count holds its value.
- R3: A period write (periodWr high) leaves the running count untouched. The new period value is used at the next reload from zero.
- R4: capIn passes through a two-flop synchronizer before edge detection. Take the first clock edge at which capIn is sampled high after being low. On the second edge after it, cmpValue takes the count that was visible just before that edge. Level and falling edges capture nothing.
- R5: With the period at all ones and a square wave on capIn, the difference (previous capture minus current capture) modulo 2^WIDTH equals the wave period in clocks. This holds even when the count wraps between the two captures.
- R6: With the period at all ones and no reload in between, all ones minus the captured value equals the number of decrements from the period value up to the capturing edge.
- R7: cmpWr high loads cmpIn into cmpValue on the next edge. A capture in the same cycle takes priority over the write.
- R8: capPending rises with each capture and clears on the edge that samples capRd high. A capture in the same cycle as the read keeps it set.
- R9: A capture that arrives while capPending is set and capRd is low sets capOverrun, and cmpValue then holds the newest capture. A capRd clears capOverrun.
- R10: irqSel selects the interrupt source:

  | irqSel | irq source |
  |---|---|
  | 0 | compare match (enable high and count equal to cmpValue) |
  | 1 | terminal count (enable high and count zero) |
  | 2 | capture |
  | 3 | off |

  irq goes high on the clock after the selected event, for one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Count enable |
| periodWr | input | 1 | Period register write strobe |
| periodIn | input | WIDTH | New period value |
| cmpWr | input | 1 | Compare register write strobe |
| cmpIn | input | WIDTH | New compare value |
| capIn | input | 1 | Asynchronous capture input, rising-edge active |
| capRd | input | 1 | Read acknowledge for the captured value |
| irqSel | input | 2 | Interrupt source select |
| count | output | WIDTH | Running count |
| cmpValue | output | WIDTH | Compare / captured value |
| capPending | output | 1 | Unread capture present |
| capOverrun | output | 1 | A capture was overwritten before it was read |
| irq | output | 1 | Interrupt pulse |

## Verification
A wrong count or a reload value that is off shows on the count port within one clock. It also shifts every later capture by the same amount, so the differences between square-wave captures expose it across the wrap.

A synchronizer of the wrong depth, or an edge detector that fires on a level, moves or repeats the captured value. Either fault appears as a cmpValue mismatch two to three clocks after capIn changes.

Errors in the flag and interrupt state show on capPending, capOverrun or irq in the cycle that follows the capture, read or count event. A reference model compared on every clock therefore catches each fault within a few cycles of its cause.

// File: rtl/timerPkg.sv
package timerPkg;
  typedef struct packed {
    logic decr;
    logic reload;
    logic capture;
    logic loadCmp;
  } strobeT;

  typedef struct packed {
    logic atZero;
    logic atCmp;
  } statusT;

  typedef enum logic [1:0] {
    IRQ_CMP = 2'd0,
    IRQ_TC  = 2'd1,
    IRQ_CAP = 2'd2,
    IRQ_OFF = 2'd3
  } irqSelT;
endpackage

// File: rtl/countPath.sv
module countPath
  import timerPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic             periodWr,
  input  logic [WIDTH-1:0] periodIn,
  input  logic [WIDTH-1:0] cmpIn,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] cmpValue,
  output statusT           stat
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] periodReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '1;
      count     <= '1;
      cmpValue  <= '0;
    end else begin
      if (periodWr)
        periodReg <= periodIn;

      if (stb.reload)
        count <= periodReg;
      else if (stb.decr)
        count <= count - ONE;

      if (stb.capture)
        cmpValue <= count;
      else if (stb.loadCmp)
        cmpValue <= cmpIn;
    end
  end

  always_comb begin
    stat.atZero = (count == '0);
    stat.atCmp  = (count == cmpValue);
  end
endmodule

// File: rtl/ctrlUnit.sv
module ctrlUnit
  import timerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       cmpWr,
  input  logic       capIn,
  input  logic       capRd,
  input  logic [1:0] irqSel,
  input  statusT     stat,
  output strobeT     stb,
  output logic       capPending,
  output logic       capOverrun,
  output logic       irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   capPrev;
  logic                   capEdge;
  logic                   irqNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      capPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], capIn};
      capPrev <= syncQ[LAST];
    end
  end

  assign capEdge = syncQ[LAST] & ~capPrev;

  always_comb begin
    stb.decr    = enable & ~stat.atZero;
    stb.reload  = enable & stat.atZero;
    stb.capture = capEdge;
    stb.loadCmp = cmpWr;
  end

  always_comb begin
    unique case (irqSelT'(irqSel))
      IRQ_CMP: irqNext = enable & stat.atCmp;
      IRQ_TC:  irqNext = enable & stat.atZero;
      IRQ_CAP: irqNext = capEdge;
      default: irqNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPending <= 1'b0;
      capOverrun <= 1'b0;
      irq        <= 1'b0;
    end else begin
      capPending <= capEdge | (capPending & ~capRd);
      capOverrun <= (capEdge & capPending & ~capRd) | (capOverrun & ~capRd);
      irq        <= irqNext;
    end
  end
endmodule

// File: rtl/captureTimer.sv
module captureTimer
  import timerPkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             periodWr,
  input  logic [WIDTH-1:0] periodIn,
  input  logic             cmpWr,
  input  logic [WIDTH-1:0] cmpIn,
  input  logic             capIn,
  input  logic             capRd,
  input  logic [1:0]       irqSel,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] cmpValue,
  output logic             capPending,
  output logic             capOverrun,
  output logic             irq
);
  strobeT stb;
  statusT stat;

  ctrlUnit #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cmpWr(cmpWr),
    .capIn(capIn), .capRd(capRd), .irqSel(irqSel), .stat(stat),
    .stb(stb), .capPending(capPending), .capOverrun(capOverrun), .irq(irq)
  );

  countPath #(.WIDTH(WIDTH)) path (
    .clk(clk), .rstN(rstN), .stb(stb), .periodWr(periodWr),
    .periodIn(periodIn), .cmpIn(cmpIn), .count(count),
    .cmpValue(cmpValue), .stat(stat)
  );
endmodule

// File: rtl/captureTimerChk.sv
module captureTimerChk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             cmpWr,
  input logic             capRd,
  input logic [1:0]       irqSel,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] cmpValue,
  input logic             capPending,
  input logic             capOverrun,
  input logic             irq
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // R2
  count_decr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && count != '0) |=> (count == $past(count) - ONE));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(count));

  // R9
  overrun_needs_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    capOverrun |-> capPending);

  // R7
  cmp_change_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cmpValue) |-> ($past(cmpWr) || capPending));

  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqSel == 2'd3) |=> !irq);

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capRd && !capPending) |=> !capOverrun);
endmodule

bind captureTimer captureTimerChk #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rstN(rstN), .enable(enable), .cmpWr(cmpWr), .capRd(capRd),
  .irqSel(irqSel), .count(count), .cmpValue(cmpValue),
  .capPending(capPending), .capOverrun(capOverrun), .irq(irq)
);

// File: tb/captureTimer_test.sv
`timescale 1ns/1ps
module captureTimer_test;
  localparam int W   = 8;
  localparam int ALL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN;
  logic         enable, periodWr, cmpWr, capIn, capRd;
  logic [W-1:0] periodIn, cmpIn;
  logic [1:0]   irqSel;
  logic [W-1:0] count, cmpValue;
  logic         capPending, capOverrun, irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  captureTimer #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .periodWr(periodWr),
    .periodIn(periodIn), .cmpWr(cmpWr), .cmpIn(cmpIn), .capIn(capIn),
    .capRd(capRd), .irqSel(irqSel), .count(count), .cmpValue(cmpValue),
    .capPending(capPending), .capOverrun(capOverrun), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, stepped at every rising edge
  int mCount, mPeriod, mCmp, mPend, mOvr, mIrq;
  int capHist[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = ALL; mPeriod = ALL; mCmp = 0;
      mPend = 0; mOvr = 0; mIrq = 0;
      capHist = '{0, 0, 0};
    end else begin
      int  old;
      bit  edgeNow, tcEv, cmpEv;
      old     = mCount;
      edgeNow = (capHist[1] == 1) && (capHist[2] == 0);
      tcEv    = enable && (old == 0);
      cmpEv   = enable && (old == mCmp);
      case (irqSel)
        2'd0:    mIrq = cmpEv;
        2'd1:    mIrq = tcEv;
        2'd2:    mIrq = edgeNow;
        default: mIrq = 0;
      endcase
      if (edgeNow)     mCmp = old;
      else if (cmpWr)  mCmp = int'(cmpIn);
      if (enable)      mCount = (old == 0) ? mPeriod : ((old - 1) & ALL);
      if (periodWr)    mPeriod = int'(periodIn);
      mOvr  = ((edgeNow && mPend && !capRd) || (mOvr && !capRd)) ? 1 : 0;
      mPend = (edgeNow || (mPend && !capRd)) ? 1 : 0;
      capHist.push_front(int'(capIn));
      void'(capHist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      check(int'(count) == mCount, "R2 count", int'(count), mCount);
      check(int'(cmpValue) == mCmp, "R4/R7 cmpValue", int'(cmpValue), mCmp);
      check(int'(capPending) == mPend, "R8 capPending", int'(capPending), mPend);
      check(int'(capOverrun) == mOvr, "R9 capOverrun", int'(capOverrun), mOvr);
      check(int'(irq) == mIrq, "R10 irq", int'(irq), mIrq);
    end
  end

  task automatic waitCount(input int target);
    for (int i = 0; i < 600; i++) begin
      if (int'(count) == target) break;
      @(negedge clk);
    end
  endtask

  task automatic readPulse();
    capRd = 1'b1;
    @(negedge clk);
    capRd = 1'b0;
  endtask

  // R5: square wave of period 2*half, captured values read back
  task automatic measureWave(input int half);
    int caps[$];
    int phase;
    phase = 0;
    capIn = 1'b0;
    for (int i = 0; i < 10 * half + 8; i++) begin
      @(negedge clk);
      capRd = 1'b0;
      if (capPending) begin
        caps.push_back(int'(cmpValue));
        capRd = 1'b1;
      end
      phase++;
      if (phase == half) begin
        phase = 0;
        capIn = ~capIn;
      end
    end
    @(negedge clk);
    capRd = 1'b0;
    capIn = 1'b0;
    check(caps.size() >= 4, "R5 capture count", caps.size(), 4);
    for (int i = 1; i < caps.size(); i++)
      check(((caps[i-1] - caps[i]) & ALL) == 2 * half, "R5 period diff",
            (caps[i-1] - caps[i]) & ALL, 2 * half);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int x, cap, first, hits;
    rstN = 1'b0; enable = 1'b0; periodWr = 1'b0; cmpWr = 1'b0;
    capIn = 1'b0; capRd = 1'b0; periodIn = '0; cmpIn = '0; irqSel = 2'd3;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(int'(count) == ALL, "R1 count", int'(count), ALL);
    check(int'(cmpValue) == 0, "R1 cmpValue", int'(cmpValue), 0);
    check(capPending == 1'b0 && capOverrun == 1'b0 && irq == 1'b0, "R1 flags",
          int'({capPending, capOverrun, irq}), 0);
    rstN = 1'b1; enable = 1'b1;
    repeat (10) @(negedge clk);

    // R4 / R6 elapsed from fresh load
    x = int'(count);
    capIn = 1'b1;
    for (int i = 0; i < 10 && !capPending; i++) @(negedge clk);
    cap = int'(cmpValue);
    check(cap == x - 2, "R4 captured count", cap, x - 2);
    check(ALL - cap == (ALL - x) + 2, "R6 elapsed", ALL - cap, (ALL - x) + 2);
    capIn = 1'b0;
    readPulse();
    check(capPending == 1'b0, "R8 cleared by read", int'(capPending), 0);

    // R7 compare write
    cmpWr = 1'b1; cmpIn = 8'h5A;
    @(negedge clk);
    cmpWr = 1'b0;
    check(int'(cmpValue) == 'h5A, "R7 compare write", int'(cmpValue), 'h5A);

    // R10 compare match interrupt
    irqSel = 2'd0;
    x = (int'(count) - 20) & ALL;
    cmpWr = 1'b1; cmpIn = W'(x);
    @(negedge clk);
    cmpWr = 1'b0;
    waitCount(x);
    @(negedge clk);
    check(irq == 1'b1, "R10 compare irq", int'(irq), 1);

    // R10 terminal count interrupt, R2 reload to all ones
    irqSel = 2'd1;
    waitCount(0);
    @(negedge clk);
    check(irq == 1'b1, "R10 terminal irq", int'(irq), 1);
    check(int'(count) == ALL, "R2 reload", int'(count), ALL);

    // R2 enable low holds
    enable = 1'b0;
    @(negedge clk);
    x = int'(count);
    repeat (5) @(negedge clk);
    check(int'(count) == x, "R2 hold", int'(count), x);
    enable = 1'b1;

    // R10 off
    irqSel = 2'd3;
    hits = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
    check(hits == 0, "R10 irq off", hits, 0);

    // R5 square waves, second one wraps the count
    irqSel = 2'd2;
    measureWave(20);
    measureWave(75);

    // R9 overrun
    capIn = 1'b1; repeat (4) @(negedge clk);
    capIn = 1'b0; repeat (2) @(negedge clk);
    first = int'(cmpValue);
    repeat (2) @(negedge clk);
    capIn = 1'b1; repeat (4) @(negedge clk);
    capIn = 1'b0; repeat (4) @(negedge clk);
    check(capOverrun == 1'b1 && capPending == 1'b1, "R9 overrun set",
          int'({capOverrun, capPending}), 3);
    check(int'(cmpValue) != first, "R9 newest kept", int'(cmpValue), first);
    readPulse();
    check(capOverrun == 1'b0 && capPending == 1'b0, "R9 cleared by read",
          int'({capOverrun, capPending}), 0);

    // R3 period write applies at next reload only
    waitCount(200);
    periodWr = 1'b1; periodIn = 8'd10;
    @(negedge clk);
    periodWr = 1'b0;
    check(int'(count) == 199, "R3 no immediate load", int'(count), 199);
    waitCount(0);
    @(negedge clk);
    check(int'(count) == 10, "R3 new period used", int'(count), 10);
    @(negedge clk);
    check(int'(count) == 9, "R3 after reload", int'(count), 9);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule